// File: doc/BRIEF.md
# Skewed Strobe Delay-Test Sequencer

This block lets slow external test equipment measure path delays inside a fast chip. From a single fast reference clock it builds a slow test cycle of N reference cycles, where N is a slowdown factor chosen at run time. The flip-flops under test keep receiving a clock enable on every reference cycle. New input vectors are launched once per slow cycle. The output-capture point sits a chosen number of reference cycles after each launch.

The whole vector sequence is run N times, and each run is called a pass. On pass k the capture strobe falls k reference cycles after the apply strobe. Successive passes therefore sample the responses one rated period later inside the slow cycle. A run takes N·N·V reference cycles for V vectors, plus one trailing capture cycle. When the run ends, the block raises a one-cycle completion flag.

A run is started with a single-cycle start pulse. The slowdown factor and the vector count are captured at that moment. The block then generates all strobes without further help. Vector storage, response comparison and fault analysis are handled elsewhere and are driven by the strobes this block emits.

Top module: `dts_skew_seq`

## Requirements
- R1: While reset is applied, and after it is released, all strobe and clock outputs are low and `pass_idx` is 0.
- R2: A start pulse with a factor from 1 to 16 and a nonzero vector count begins a run on the next cycle. That first cycle is phase 0 of vector 0, with `pass_idx` equal to 1.
- R3: A start pulse is ignored when the factor or the vector count is 0: all outputs stay as they were. A factor above 16 is treated as 16.
- R4: Each slow cycle lasts N reference cycles. `apply_stb` pulses in its first cycle (phase 0). `test_clk` is high in phases 0 to ceil(N/2)-1 and low in the remaining phases and outside a run.
- R5: On pass k with k < N, `capture_stb` pulses in phase k of every slow cycle and never coincides with `apply_stb`.
- R6: On pass N, `capture_stb` pulses in phase 0 of each slow cycle after the first, coinciding with the next apply. One extra capture-only cycle follows the last slow cycle. For N = 1 this gives at-speed testing.
- R7: The vector counter advances once per slow cycle and wraps to 0 after the programmed count. `pass_idx` then increments, so a run spans N·N·V reference cycles before the trailing cycle.
- R8: `ff_clk_en` is high in every cycle from the first run cycle through the trailing capture cycle, and low otherwise.
- R9: `done` is high for exactly one cycle, the cycle after the trailing capture cycle. `pass_idx` then holds N until the next start.
- R10: Changes to the factor or the vector count during a run have no effect on that run.
- R11: A valid start pulse during a run abandons it and restarts from pass 1, vector 0, phase 0 with the new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle run request |
| slow_factor | input | 5 | Slowdown factor N, 1 to 16 |
| vec_count | input | 8 | Vectors per pass |
| test_clk | output | 1 | Slow test clock level |
| ff_clk_en | output | 1 | Rated-rate enable for flip-flops under test |
| apply_stb | output | 1 | Vector launch pulse |
| capture_stb | output | 1 | Response capture pulse |
| pass_idx | output | 5 | Current pass number, 1 to N |
| done | output | 1 | One-cycle run-complete pulse |

## Verification
The bench targets the final pass, where capture and apply share a cycle. A design that misplaced this would either drop the capture of the last vector, which is caught by the trailing-cycle check, or add a spurious capture before vector 0. N = 1 and odd N exercise the phase wrap and the test clock duty: an off-by-one there would shift every strobe or stretch the high phase. Factor and count are changed mid-run, and the run is restarted mid-run, to catch settings that are not latched or restarts that leave stale pass or vector state behind.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dts_reset_sync.sv
module dts_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/dts_phase_timer.sv
module dts_phase_timer #(
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [NW-1:0] n_q,
  output logic [NW-1:0] ph,
  output logic          ph_last
);
  logic [NW-1:0] ph_d;

  assign ph_last = (ph == n_q - NW'(1));

  always_comb begin
    ph_d = ph;
    if (clear)    ph_d = '0;
    else if (run) ph_d = ph_last ? '0 : ph + NW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph_d;
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q == '0) || (ph < n_q)); // R4
endmodule

// File: rtl/dts_pass_tracker.sv
module dts_pass_tracker #(
  parameter int NW = 5,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [NW-1:0] n_q,
  input  logic [VW-1:0] cnt_q,
  output logic [NW-1:0] pass,
  output logic          vec_zero,
  output logic          final_step
);
  logic [VW-1:0] vec, vec_d;
  logic [NW-1:0] pass_d;
  logic          vec_last, pass_last;

  assign vec_last   = (vec == cnt_q - VW'(1));
  assign pass_last  = (pass == n_q);
  assign vec_zero   = (vec == '0);
  assign final_step = step && vec_last && pass_last;

  always_comb begin
    vec_d  = vec;
    pass_d = pass;
    if (clear) begin
      vec_d  = '0;
      pass_d = NW'(1);
    end else if (step) begin
      if (!vec_last) begin
        vec_d = vec + VW'(1);
      end else begin
        vec_d = '0;
        if (!pass_last) pass_d = pass + NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec  <= '0;
      pass <= '0;
    end else begin
      vec  <= vec_d;
      pass <= pass_d;
    end
  end

  AST_PASS_LE_N: assert property (@(posedge clk) disable iff (!rst_n)
    pass <= n_q); // R7
  AST_VEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && vec_last) |=> vec_zero); // R7
endmodule

// File: rtl/dts_strobe_gen.sv
module dts_strobe_gen #(
  parameter int NW = 5
) (
  input  logic          run,
  input  logic          drain,
  input  logic [NW-1:0] ph,
  input  logic [NW-1:0] pass,
  input  logic [NW-1:0] n_q,
  input  logic          vec_zero,
  output logic          apply_stb,
  output logic          capture_stb,
  output logic          test_clk,
  output logic          ff_clk_en
);
  logic          ph_zero, on_last_pass;
  logic [NW:0]   half;

  assign ph_zero      = (ph == '0);
  assign on_last_pass = (pass == n_q);
  assign half         = ({1'b0, n_q} + (NW+1)'(1)) >> 1;

  always_comb begin
    apply_stb   = run && ph_zero;
    capture_stb = drain ||
                  (run && !on_last_pass && (ph == pass)) ||
                  (run && on_last_pass && ph_zero && !vec_zero);
    test_clk    = run && ({1'b0, ph} < half);
    ff_clk_en   = run || drain;
  end
endmodule

// File: rtl/dts_skew_seq.sv
module dts_skew_seq #(
  parameter int MAX_N = 16,
  parameter int VW    = 8,
  localparam int NW   = $clog2(MAX_N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] slow_factor,
  input  logic [VW-1:0] vec_count,
  output logic          test_clk,
  output logic          ff_clk_en,
  output logic          apply_stb,
  output logic          capture_stb,
  output logic [NW-1:0] pass_idx,
  output logic          done
);
  import dts_pkg::*;

  logic          srst_n;
  seq_state_e    state_q, state_d;
  logic [NW-1:0] n_q, n_d, eff_n;
  logic [VW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          start_ok, run, drain;
  logic [NW-1:0] ph, pass;
  logic          ph_last, vec_zero, final_step;

  dts_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(srst_n)
  );

  assign eff_n    = (slow_factor > NW'(MAX_N)) ? NW'(MAX_N) : slow_factor;
  assign start_ok = start && (eff_n != '0) && (vec_count != '0);
  assign run      = (state_q == ST_RUN);
  assign drain    = (state_q == ST_DRAIN);

  always_comb begin
    state_d = state_q;
    n_d     = n_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (start_ok) begin
      state_d = ST_RUN;
      n_d     = eff_n;
      cnt_d   = vec_count;
    end else begin
      case (state_q)
        ST_RUN:   if (final_step) state_d = ST_DRAIN;
        ST_DRAIN: begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      n_q     <= n_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  dts_phase_timer #(.NW(NW)) u_phase (
    .clk(clk), .rst_n(srst_n), .clear(start_ok), .run(run),
    .n_q(n_q), .ph(ph), .ph_last(ph_last)
  );

  dts_pass_tracker #(.NW(NW), .VW(VW)) u_pass (
    .clk(clk), .rst_n(srst_n), .clear(start_ok), .step(run && ph_last),
    .n_q(n_q), .cnt_q(cnt_q), .pass(pass), .vec_zero(vec_zero),
    .final_step(final_step)
  );

  dts_strobe_gen #(.NW(NW)) u_strobe (
    .run(run), .drain(drain), .ph(ph), .pass(pass), .n_q(n_q),
    .vec_zero(vec_zero), .apply_stb(apply_stb), .capture_stb(capture_stb),
    .test_clk(test_clk), .ff_clk_en(ff_clk_en)
  );

  assign pass_idx = pass;
  assign done     = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!srst_n)
    done |=> !done); // R9
  AST_STROBE_SOLO: assert property (@(posedge clk) disable iff (!srst_n)
    (apply_stb && capture_stb) |-> (pass_idx == n_q)); // R5
  AST_APPLY_ENABLED: assert property (@(posedge clk) disable iff (!srst_n)
    (apply_stb || capture_stb) |-> ff_clk_en); // R8
  AST_SETTINGS_HELD: assert property (@(posedge clk) disable iff (!srst_n)
    (run && !start_ok) |=> $stable(n_q) && $stable(cnt_q)); // R10
  AST_RESTART: assert property (@(posedge clk) disable iff (!srst_n)
    start_ok |=> (run && pass_idx == 1 && apply_stb)); // R11
endmodule

// File: tb/dts_skew_seq_tb.sv
module dts_skew_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       tclk, en, app, cap, dn;
    logic [4:0] pidx;
    string      tag;
  } exp_t;

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [4:0] slow_factor = '0;
  logic [7:0] vec_count = '0;
  logic       test_clk, ff_clk_en, apply_stb, capture_stb, done;
  logic [4:0] pass_idx;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, cyc = 0;
  int   last_pass = 0;

  dts_skew_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .slow_factor(slow_factor),
    .vec_count(vec_count), .test_clk(test_clk), .ff_clk_en(ff_clk_en),
    .apply_stb(apply_stb), .capture_stb(capture_stb), .pass_idx(pass_idx),
    .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic compare(exp_t e);
    logic [9:0] act, expv;
    act  = {test_clk, ff_clk_en, apply_stb, capture_stb, done, pass_idx};
    expv = {e.tclk, e.en, e.app, e.cap, e.dn, e.pidx};
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cyc %0d: tclk/en/app/cap/done/pass actual %b expected %b",
               e.tag, cyc, act, expv);
    end
  endtask

  // monitor: pop one expected item per cycle
  always @(negedge clk) begin
    cyc++;
    if (q.size() > 0) compare(q.pop_front());
  end

  function automatic exp_t idle_item(logic dn, string tag);
    exp_t e;
    e.tclk = 0; e.en = 0; e.app = 0; e.cap = 0; e.dn = dn;
    e.pidx = 5'(last_pass); e.tag = tag;
    return e;
  endfunction

  // driver side: expected trace of a whole run
  task automatic push_run(int n, int cnt, string tag);
    exp_t e;
    for (int p = 1; p <= n; p++)
      for (int v = 0; v < cnt; v++)
        for (int ph = 0; ph < n; ph++) begin
          e.app  = (ph == 0);                              // R4
          e.cap  = (p < n && ph == p) ||                   // R5
                   (p == n && ph == 0 && v != 0);          // R6
          e.tclk = (ph < (n + 1) / 2);                     // R4
          e.en   = 1;                                      // R8
          e.dn   = 0;
          e.pidx = 5'(p);                                  // R7
          e.tag  = tag;
          q.push_back(e);
        end
    last_pass = n;
    e.app = 0; e.cap = 1; e.tclk = 0; e.en = 1; e.dn = 0;  // R6 trailing
    e.pidx = 5'(n); e.tag = tag;
    q.push_back(e);
    q.push_back(idle_item(1'b1, tag));                     // R9
    q.push_back(idle_item(1'b0, tag));                     // R9
  endtask

  task automatic pulse_start(int fac, int cnt);
    @(posedge clk); #1;
    start = 1; slow_factor = 5'(fac); vec_count = 8'(cnt);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic drain_q();
    while (q.size() != 0) @(posedge clk);
    @(posedge clk);
  endtask

  task automatic run_case(int fac, int n, int cnt, string tag);
    pulse_start(fac, cnt);
    push_run(n, cnt, tag);
    drain_q();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : stim
    exp_t e;
    // R1: outputs during and after reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(idle_item(1'b0, "R1 in reset"));
    @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    compare(idle_item(1'b0, "R1 after reset"));

    run_case(2, 2, 1, "R2 R5 R6 n2");
    run_case(1, 1, 3, "R6 R7 n1 at-speed");
    run_case(3, 3, 2, "R4 R5 R7 n3 odd");

    // R10: settings changed mid-run
    pulse_start(4, 2);
    push_run(4, 2, "R10 n4");
    @(posedge clk); #1 slow_factor = 5'd9; vec_count = 8'd5;
    drain_q();

    // R3: zero factor / zero count ignored
    pulse_start(0, 3);
    repeat (3) q.push_back(idle_item(1'b0, "R3 zero factor"));
    drain_q();
    pulse_start(2, 0);
    repeat (3) q.push_back(idle_item(1'b0, "R3 zero count"));
    drain_q();

    // R3: factor clamped to 16
    run_case(25, 16, 1, "R3 clamp");

    // R11: restart during a run
    pulse_start(3, 3);
    push_run(3, 3, "R11 first");
    repeat (7) @(posedge clk);
    #1 start = 1; slow_factor = 5'd2; vec_count = 8'd1;
    @(posedge clk); #1 start = 0;
    q.delete();
    push_run(2, 1, "R11 restarted");
    drain_q();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule